// File: doc/BRIEF.md
# Variable-Length Serial Frame Shifter

This block is the master side of a simple serial link. One start request sends a frame of one to eight data bits on a data-out line. The block drives the serial clock for every bit and collects the same number of bits from a data-in line. An 8-bit mode register sets four things: the bit order, an optional wait before the acknowledge slot, the serial clock rate and the frame length. A format input adds one acknowledge clock after the data bits. In that clock the block releases data-out high and captures the level on data-in.

When a frame is shorter than eight bits, where the bits sit in the bytes depends on the bit order. In MSB-first order, the bits to send come from the top end of the transmit byte and received bits gather at the bottom end of the receive byte. In LSB-first order it is the other way round. The acknowledged format always runs MSB-first, whatever the order bit holds. A busy output covers the whole frame and a one-cycle done pulse marks its end.

Top module: `frame_shifter`

## Requirements
- R1: After reset the mode register reads 0, sclk is 1, sdo is 1, and busy, done, ack_in and rx_data are all 0.
- R2: A write to the mode register takes effect only in a cycle where mode_we and if_en are both 1. At other times mode_q holds its value. The field layout is: bit 7 = LSB-first order, bit 6 = wait before acknowledge, bits 5:3 = clock select, bits 2:0 = bit count.
- R3: A bit count of 0 gives 8 data bits, and a count of 1 to 7 gives that many data bits. A frame has exactly that many rising sclk edges, plus one more in the acknowledged format.
- R4: Each sclk half-period lasts 2^(clock select + 2) system clocks. busy stays high for half × (2·bits + extra) cycles. The extra is 0 in the synchronous format, 2 in the acknowledged format, and 3 in the acknowledged format with wait set.
- R5: Transmit order. With order 0, bit k of the frame is tx_data[7-k]. With order 1, bit k is tx_data[k]. So a short frame takes its bits from the MSB end of tx_data in MSB-first order and from the LSB end in LSB-first order.
- R6: Receive placement. With order 0, received bit k lands at rx_data[bits-1-k]. With order 1, it lands at rx_data[8-bits+k]. All other bits of rx_data are 0.
- R7: With ack_fmt = 1, sdo is 1 during the acknowledge clock, and ack_in holds the sdi level sampled at that clock's rising edge. The frame runs MSB-first even when the order bit is 1. With ack_fmt = 0, ack_in is 0.
- R8: With wait set in the acknowledged format, sclk stays low for two half-periods before the acknowledge rising edge. Wait has no effect in the synchronous format.
- R9: sclk idles high. sdo changes only while sclk is low. sdi is sampled at each rising edge of sclk.
- R10: done is high for exactly one cycle, in the first cycle after busy falls. A start received while busy is ignored, and tx_data is taken only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_en | input | 1 | Interface enable; gates mode register writes |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| mode_q | output | 8 | Current mode register value |
| ack_fmt | input | 1 | 1 = acknowledged format, 0 = plain synchronous format |
| start | input | 1 | Request to begin a frame (accepted when idle) |
| tx_data | input | 8 | Byte to transmit, captured at start |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rx_data | output | 8 | Received bits, justified by bit order |
| ack_in | output | 1 | sdi level sampled in the acknowledge clock |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions check on every cycle the rules that hold whatever the configuration. sclk is high when idle. sdo never changes while sclk is high. sdo stays released during the acknowledge slot. done lasts one cycle and never overlaps busy. The half-period counter stays in range. Mode register changes happen only on an enabled write. Only the bench's sweeps can show the rest, because it depends on values: which tx_data bit goes out at each edge, where received bits land for every length and order, the forced MSB-first order in the acknowledged format, and the exact frame length in cycles, including the wait half-period. The sweeps cover two clock rates, all eight lengths, both orders and all four combinations of format and wait.

// File: rtl/frame_shifter_pkg.sv
package frame_shifter_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic       lsb_first;
    logic       wait_ack;
    logic [2:0] clk_sel;
    logic [2:0] bit_cnt;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLOW,
    ST_DHIGH,
    ST_WAIT,
    ST_ALOW,
    ST_AHIGH
  } state_t;

  // number of data bits selected by the count field (0 encodes eight)
  function automatic logic [3:0] frame_len(input logic [2:0] cnt);
    return (cnt == 3'd0) ? 4'd8 : {1'b0, cnt};
  endfunction

  // system clocks per sclk half-period
  function automatic int unsigned half_cycles(input logic [2:0] sel,
                                              input int unsigned base_log);
    return 32'd1 << (32'(sel) + base_log);
  endfunction

endpackage

// File: rtl/fs_modereg.sv
module fs_modereg
  import frame_shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] q
);

  logic wr_ok;
  assign wr_ok = we && if_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_ok) q <= wdata;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(q) |-> $past(we && if_en));

endmodule

// File: rtl/fs_halfgen.sv
module fs_halfgen
  import frame_shifter_pkg::*;
#(
  parameter int unsigned BASE_LOG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       phase_end
);

  localparam int unsigned CNT_W = 7 + BASE_LOG;

  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_new;
  logic [CNT_W-1:0] reload_cur;

  assign reload_new = CNT_W'(half_cycles(sel,   BASE_LOG) - 1);
  assign reload_cur = CNT_W'(half_cycles(sel_q, BASE_LOG) - 1);
  assign phase_end  = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      sel_q <= sel;
      cnt   <= reload_new;
    end else if (run) begin
      cnt   <= (cnt == '0) ? reload_cur : cnt - 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= reload_cur));

endmodule

// File: rtl/fs_shiftpath.sv
module fs_shiftpath
  import frame_shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              lsb_in,
  input  logic [BYTE_W-1:0] tx_in,
  input  logic              step,
  input  logic              sdi_in,
  output logic              tx_bit,
  output logic [BYTE_W-1:0] rx_byte
);

  logic              lsb_q;
  logic [BYTE_W-1:0] txs;

  assign tx_bit = lsb_q ? txs[0] : txs[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q   <= 1'b0;
      txs     <= '0;
      rx_byte <= '0;
    end else if (load) begin
      lsb_q   <= lsb_in;
      txs     <= tx_in;
      rx_byte <= '0;
    end else if (step) begin
      txs     <= lsb_q ? (txs >> 1) : (txs << 1);
      rx_byte <= lsb_q ? {sdi_in, rx_byte[BYTE_W-1:1]}
                       : {rx_byte[BYTE_W-2:0], sdi_in};
    end
  end

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import frame_shifter_pkg::*;
#(
  parameter int unsigned BASE_LOG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  output logic [7:0] mode_q,
  input  logic       ack_fmt,
  input  logic       start,
  input  logic [7:0] tx_data,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       ack_in,
  output logic       sclk,
  output logic       sdo,
  input  logic       sdi
);

  mode_t      mode;
  state_t     st;
  logic [3:0] bits_left;
  logic       fmt_q, wait_q;
  logic       sclk_q, sdo_q, done_q, ack_q;
  logic       accept, phase_end, eff_lsb, next_bit;
  logic       rise_data, ack_phase;

  fs_modereg u_mode (
    .clk(clk), .rst_n(rst_n), .if_en(if_en),
    .we(mode_we), .wdata(mode_wdata), .q(mode_q)
  );

  assign mode      = mode_t'(mode_q);
  assign busy      = (st != ST_IDLE);
  assign accept    = start && !busy;
  assign eff_lsb   = mode.lsb_first && !ack_fmt;
  assign rise_data = (st == ST_DLOW) && phase_end;
  assign ack_phase = (st == ST_WAIT) || (st == ST_ALOW) || (st == ST_AHIGH);

  fs_halfgen #(.BASE_LOG(BASE_LOG)) u_half (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .sel(mode.clk_sel), .phase_end(phase_end)
  );

  fs_shiftpath u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .lsb_in(eff_lsb),
    .tx_in(tx_data), .step(rise_data), .sdi_in(sdi),
    .tx_bit(next_bit), .rx_byte(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bits_left <= '0;
      fmt_q     <= 1'b0;
      wait_q    <= 1'b0;
      sclk_q    <= 1'b1;
      sdo_q     <= 1'b1;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st        <= ST_DLOW;
          bits_left <= frame_len(mode.bit_cnt);
          fmt_q     <= ack_fmt;
          wait_q    <= mode.wait_ack;
          sclk_q    <= 1'b0;
          sdo_q     <= eff_lsb ? tx_data[0] : tx_data[7];
          ack_q     <= 1'b0;
        end
        ST_DLOW: if (phase_end) begin
          st        <= ST_DHIGH;
          sclk_q    <= 1'b1;
          bits_left <= bits_left - 1'b1;
        end
        ST_DHIGH: if (phase_end) begin
          if (bits_left != '0) begin
            st     <= ST_DLOW;
            sclk_q <= 1'b0;
            sdo_q  <= next_bit;
          end else if (fmt_q) begin
            st     <= wait_q ? ST_WAIT : ST_ALOW;
            sclk_q <= 1'b0;
            sdo_q  <= 1'b1;
          end else begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_WAIT: if (phase_end) st <= ST_ALOW;
        ST_ALOW: if (phase_end) begin
          st     <= ST_AHIGH;
          sclk_q <= 1'b1;
          ack_q  <= sdi;
        end
        ST_AHIGH: if (phase_end) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk   = sclk_q;
  assign sdo    = sdo_q;
  assign done   = done_q;
  assign ack_in = ack_q;

  // R9
  sdo_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sdo_q) |-> !sclk_q);

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_q);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_phase |-> sdo_q);

  // R3
  bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= 4'd8);

endmodule

// File: tb/frame_shifter_bench.sv
`timescale 1ns/1ps
module frame_shifter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       if_en = 1'b0, mode_we = 1'b0, ack_fmt = 1'b0, start = 1'b0, sdi = 1'b0;
  logic [7:0] mode_wdata = '0, tx_data = '0;
  logic [7:0] mode_q, rx_data;
  logic       busy, done, ack_in, sclk, sdo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  frame_shifter u_frame_shifter (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .mode_q(mode_q), .ack_fmt(ack_fmt),
    .start(start), .tx_data(tx_data), .busy(busy), .done(done),
    .rx_data(rx_data), .ack_in(ack_in), .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic en, input logic [7:0] v);
    @(negedge clk);
    if_en = en; mode_we = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0; if_en = 1'b1;
  endtask

  task automatic run_frame(input logic [2:0] cks, input logic [2:0] bc,
                           input logic ord, input logic wt, input logic fmt,
                           input logic [7:0] tx, input logic [7:0] rxp,
                           input logic ackv, input bit poke);
    int h, n, expc, cyc, r, lowrun, lastlow;
    logic eo, prev, ack_sdo;
    logic [7:0] got, expt, expr, mask;
    h = 1 << (int'(cks) + 2);
    n = (bc == 3'd0) ? 8 : int'(bc);
    eo = ord && !fmt;
    expc = h * (2 * n + (fmt ? (2 + int'(wt)) : 0));
    got = '0; expt = '0; expr = '0; mask = '0;
    for (int k = 0; k < n; k++) begin
      mask[k] = 1'b1;
      expt[k] = eo ? tx[k] : tx[7 - k];
      if (eo) expr[8 - n + k] = rxp[k];
      else    expr[n - 1 - k] = rxp[k];
    end
    write_mode(1'b1, {ord, wt, cks, bc});
    @(negedge clk);
    tx_data = tx; ack_fmt = fmt; start = 1'b1; sdi = rxp[0];
    @(negedge clk);
    start = 1'b0;
    prev = 1'b1; cyc = 0; r = 0; lowrun = 0; lastlow = 0; ack_sdo = 1'b0;
    while (busy && cyc < 6000) begin
      cyc++;
      if (poke && cyc == 3) begin start = 1'b1; tx_data = ~tx; end
      else start = 1'b0;
      if (!sclk) begin
        lowrun++;
        sdi = (r < n) ? rxp[r] : ackv;
      end else if (!prev) begin
        if (r < n) got[r] = sdo;
        else begin ack_sdo = sdo; lastlow = lowrun; end
        r++;
        lowrun = 0;
      end
      prev = sclk;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == expc, "R4 busy length", cyc, expc);
    chk(r == n + int'(fmt), "R3 rising edges", r, n + int'(fmt));
    chk((got & mask) == expt, poke ? "R10 tx kept despite busy start" : "R5 tx bits",
        int'(got & mask), int'(expt));
    chk(rx_data == expr, "R6 rx placement", int'(rx_data), int'(expr));
    chk(done == 1'b1 && sclk == 1'b1, "R10 done after frame", int'(done), 1);
    if (fmt) begin
      chk(ack_in == ackv, "R7 ack capture", int'(ack_in), int'(ackv));
      chk(ack_sdo == 1'b1, "R7 ack released", int'(ack_sdo), 1);
      chk(lastlow == (wt ? 2 * h : h), "R8 wait low time", lastlow, wt ? 2 * h : h);
    end else begin
      chk(ack_in == 1'b0, "R7 no ack in sync", int'(ack_in), 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && sclk == 1 && sdo == 1, "R1 idle outputs",
        int'({busy, done, sclk, sdo}), 3);
    chk(mode_q == 8'h00 && rx_data == 8'h00 && ack_in == 0, "R1 reset regs",
        int'(mode_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    write_mode(1'b0, 8'h5A);
    chk(mode_q == 8'h00, "R2 write ignored when disabled", int'(mode_q), 0);
    write_mode(1'b1, 8'hC9);
    chk(mode_q == 8'hC9, "R2 enabled write", int'(mode_q), 8'hC9);
    write_mode(1'b0, 8'h12);
    chk(mode_q == 8'hC9, "R2 disabled write keeps value", int'(mode_q), 8'hC9);

    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 8; b++)
        for (int o = 0; o < 2; o++)
          for (int f = 0; f < 4; f++) begin
            logic [7:0] tx, rxp;
            tx  = 8'h3C + 8'(b * 29) + 8'(o * 7) + 8'(f * 53);
            rxp = ~tx ^ 8'(c * 90);
            run_frame(3'(c), 3'(b), o[0], f[0], f[1], tx, rxp, b[0] ^ f[0], 1'b0);
          end

    run_frame(3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 8'hB2, 8'h4D, 1'b0, 1'b1);
    run_frame(3'd1, 3'd3, 1'b1, 1'b1, 1'b1, 8'h71, 8'hE6, 1'b1, 1'b1);
    run_frame(3'd7, 3'd1, 1'b1, 1'b0, 1'b0, 8'h01, 8'h01, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule